// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache that sits between a processor load/store port and a slower next-level memory. Each set keeps two lines, and each line has a valid flag, a dirty flag, a tag and 64 bytes of data. A request carries a separate tag and an address field that holds the set index and the byte offset. The set is looked up by comparing both stored tags at once. A hit returns the selected 32-bit word, or merges the store bytes into the line, one cycle after the request is taken.

On a miss the controller picks a victim inside the set. An empty way is taken first. Otherwise the way used least recently is taken. A dirty victim is first written out as a whole line. The wanted line is then read in, and the request is replayed so that it completes as a hit. A store miss therefore allocates the line and merges into it. Next-level memory is only written when a dirty line is evicted.

The next-level port moves one full line per transaction. It has separate read and write strobes and a single acknowledge.

Top module: `dcache2_top`

## Requirements
- R1: Reset clears every valid, dirty and recency bit and leaves `cpu_ready`, `mem_rd` and `mem_wr` low, so the first access to any set misses.
- R2: A set holds two lines with different tags at the same time; after both are filled, an access to either hits without any next-level transaction, and at most one way ever matches a request.
- R3: A request is taken when `cpu_req` is high in the idle state; a hit raises `cpu_ready` in the very next cycle, and for a load `cpu_rdata` holds the word selected by `cpu_addr[5:2]` from the matching way.
- R4: A store hit writes only the bytes whose `cpu_be` bit is set (bit b covers `cpu_wdata[8b+7:8b]`), marks the line dirty and causes no next-level write.
- R5: A store miss first reads the line from next-level memory at line address `{cpu_tag, index}` and then merges the store into it; later loads see the merged data.
- R6: With both ways valid, a miss replaces the way used less recently, where every hit and every fill counts as a use of that way.
- R7: An invalid way in the set is filled before any valid way is replaced.
- R8: A miss whose victim is valid and dirty first writes the victim's full line to `mem_addr = {stored tag, index}`, and only after that write is acknowledged issues the refill read.
- R9: A miss whose victim is clean or invalid issues no next-level write.
- R10: `mem_rd` and `mem_wr` are never high together, and a raised strobe together with its address stays unchanged until `mem_ack`. Each acknowledged transaction carries exactly one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid; held until `cpu_ready` |
| cpu_addr | input | IDX_W+6 | Set index above a 6-bit byte offset |
| cpu_tag | input | TAG_W | Request tag |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ready | output | 1 | Request completed this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_rd | output | 1 | Line read strobe |
| mem_wr | output | 1 | Line write strobe |
| mem_addr | output | TAG_W+IDX_W | Line address `{tag, index}` |
| mem_wdata | output | 512 | Line written on eviction |
| mem_rdata | input | 512 | Line returned on refill |
| mem_ack | input | 1 | Transaction complete |

## Verification
The bench goes after evictions in both directions. When a dirty line is evicted, the single write it causes must carry every byte stored so far. A design that drops or reorders the write-back would return stale words on a later reload. When a clean line is evicted there must be no write at all, and a design that writes back blindly would show an extra transaction. The recency order is probed by touching one line of a full set before missing into it. Choosing the wrong victim turns a predicted hit into a refill. Store misses and partial byte enables are also exercised: a design without allocation or with the wrong byte lane merge would return words that differ from the bench's flat shadow copy.

// File: rtl/dcache2_pkg.sv
package dcache2_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_REFILL
    } ctl_state_e;

    localparam int unsigned DEF_SETS       = 16;
    localparam int unsigned DEF_TAG_W      = 29;
    localparam int unsigned DEF_LINE_BYTES = 64;
    localparam int unsigned DEF_WORD_BYTES = 4;
endpackage

// File: rtl/dcache2_way.sv
module dcache2_way #(
    parameter int unsigned SETS   = 16,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned TAG_W  = 29,
    parameter int unsigned LINE_W = 512,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WSEL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    look_idx,
    output logic                look_vld,
    output logic                look_dirty,
    output logic [TAG_W-1:0]    look_tag,
    output logic [LINE_W-1:0]   look_line,
    input  logic                fill_en,
    input  logic [IDX_W-1:0]    fill_idx,
    input  logic [TAG_W-1:0]    fill_tag,
    input  logic [LINE_W-1:0]   fill_line,
    input  logic                st_en,
    input  logic [IDX_W-1:0]    st_idx,
    input  logic [WSEL_W-1:0]   st_wsel,
    input  logic [WORD_W-1:0]   st_wdata,
    input  logic [WORD_W/8-1:0] st_be
);
    localparam int unsigned NBYTES = WORD_W / 8;

    logic [SETS-1:0]   vld_d, vld_q;
    logic [SETS-1:0]   dty_d, dty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    always_comb begin
        vld_d = vld_q;
        dty_d = dty_q;
        if (fill_en) begin
            vld_d[fill_idx] = 1'b1;
            dty_d[fill_idx] = 1'b0;
        end
        if (st_en) begin
            dty_d[st_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            dty_q <= '0;
        end else begin
            vld_q <= vld_d;
            dty_q <= dty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_line;
        end else if (st_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (st_be[b]) begin
                    data_q[st_idx][int'(st_wsel)*WORD_W + b*8 +: 8] <= st_wdata[b*8 +: 8];
                end
            end
        end
    end

    assign look_vld   = vld_q[look_idx];
    assign look_dirty = dty_q[look_idx];
    assign look_tag   = tag_q[look_idx];
    assign look_line  = data_q[look_idx];

    // R4
    store_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> dty_q[$past(st_idx)]);

    // R5
    fill_leaves_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (vld_q[$past(fill_idx)] && !dty_q[$past(fill_idx)]));
endmodule

// File: rtl/dcache2_lru.sv
module dcache2_lru #(
    parameter int unsigned SETS  = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             vld0,
    input  logic             vld1,
    input  logic             touch_en,
    input  logic             touch_way,
    output logic             victim
);
    // one bit per set naming the way that was used less recently
    logic [SETS-1:0] old_d, old_q;

    always_comb begin
        old_d = old_q;
        if (touch_en) begin
            old_d[idx] = ~touch_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
        end else begin
            old_q <= old_d;
        end
    end

    always_comb begin
        if (!vld0) begin
            victim = 1'b0;
        end else if (!vld1) begin
            victim = 1'b1;
        end else begin
            victim = old_q[idx];
        end
    end

    // R6
    recency_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (old_q[$past(idx)] != $past(touch_way)));
endmodule

// File: rtl/dcache2_top.sv
module dcache2_top
    import dcache2_pkg::*;
#(
    parameter int unsigned SETS       = DEF_SETS,
    parameter int unsigned TAG_W      = DEF_TAG_W,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
    localparam int unsigned IDX_W  = $clog2(SETS),
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
    localparam int unsigned AW     = IDX_W + OFF_W,
    localparam int unsigned WORD_W = WORD_BYTES * 8,
    localparam int unsigned LINE_W = LINE_BYTES * 8,
    localparam int unsigned MA_W   = TAG_W + IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic [AW-1:0]         cpu_addr,
    input  logic [TAG_W-1:0]      cpu_tag,
    input  logic                  cpu_we,
    input  logic [WORD_W-1:0]     cpu_wdata,
    input  logic [WORD_BYTES-1:0] cpu_be,
    output logic                  cpu_ready,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [MA_W-1:0]       mem_addr,
    output logic [LINE_W-1:0]     mem_wdata,
    input  logic [LINE_W-1:0]     mem_rdata,
    input  logic                  mem_ack
);
    localparam int unsigned WAYS   = 2;
    localparam int unsigned BO_W   = $clog2(WORD_BYTES);
    localparam int unsigned WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int unsigned WSEL_W = $clog2(WORDS);

    typedef struct packed {
        ctl_state_e              st;
        logic [IDX_W-1:0]        idx;
        logic [WSEL_W-1:0]       wsel;
        logic [TAG_W-1:0]        tag;
        logic                    we;
        logic [WORD_W-1:0]       wdata;
        logic [WORD_BYTES-1:0]   be;
        logic                    vic;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              w_vld  [WAYS];
    logic              w_dty  [WAYS];
    logic [TAG_W-1:0]  w_tag  [WAYS];
    logic [LINE_W-1:0] w_line [WAYS];
    logic [WAYS-1:0]   w_hit;
    logic [WAYS-1:0]   w_fill;
    logic [WAYS-1:0]   w_st;
    logic              any_hit;
    logic              hit_way;
    logic              victim;
    logic              touch_en;
    logic              touch_way;
    logic              unused_lowbits;

    assign unused_lowbits = ^cpu_addr[BO_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        dcache2_way #(
            .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W),
            .LINE_W(LINE_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .look_idx  (c_q.idx),
            .look_vld  (w_vld[w]),
            .look_dirty(w_dty[w]),
            .look_tag  (w_tag[w]),
            .look_line (w_line[w]),
            .fill_en   (w_fill[w]),
            .fill_idx  (c_q.idx),
            .fill_tag  (c_q.tag),
            .fill_line (mem_rdata),
            .st_en     (w_st[w]),
            .st_idx    (c_q.idx),
            .st_wsel   (c_q.wsel),
            .st_wdata  (c_q.wdata),
            .st_be     (c_q.be)
        );
        assign w_hit[w] = w_vld[w] && (w_tag[w] == c_q.tag);
    end

    assign any_hit = |w_hit;
    assign hit_way = w_hit[1];

    dcache2_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (c_q.idx),
        .vld0     (w_vld[0]),
        .vld1     (w_vld[1]),
        .touch_en (touch_en),
        .touch_way(touch_way),
        .victim   (victim)
    );

    assign cpu_rdata = w_line[hit_way][int'(c_q.wsel)*WORD_W +: WORD_W];

    always_comb begin
        c_d       = c_q;
        cpu_ready = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = {c_q.tag, c_q.idx};
        mem_wdata = w_line[c_q.vic];
        w_fill    = '0;
        w_st      = '0;
        touch_en  = 1'b0;
        touch_way = hit_way;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    c_d.st    = ST_LOOKUP;
                    c_d.idx   = cpu_addr[OFF_W +: IDX_W];
                    c_d.wsel  = cpu_addr[BO_W +: WSEL_W];
                    c_d.tag   = cpu_tag;
                    c_d.we    = cpu_we;
                    c_d.wdata = cpu_wdata;
                    c_d.be    = cpu_be;
                end
            end
            ST_LOOKUP: begin
                if (any_hit) begin
                    cpu_ready = 1'b1;
                    touch_en  = 1'b1;
                    w_st      = c_q.we ? w_hit : '0;
                    c_d.st    = ST_IDLE;
                end else begin
                    c_d.vic = victim;
                    c_d.st  = (w_vld[victim] && w_dty[victim]) ? ST_EVICT : ST_REFILL;
                end
            end
            ST_EVICT: begin
                mem_wr   = 1'b1;
                mem_addr = {w_tag[c_q.vic], c_q.idx};
                if (mem_ack) begin
                    c_d.st = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_rd = 1'b1;
                if (mem_ack) begin
                    w_fill[c_q.vic] = 1'b1;
                    touch_en        = 1'b1;
                    touch_way       = c_q.vic;
                    c_d.st          = ST_LOOKUP;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ack) |=>
            (mem_rd == $past(mem_rd) && mem_wr == $past(mem_wr) && $stable(mem_addr)));

    // R8
    evict_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ack) |=> mem_rd);

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(w_hit) <= 1);

    // R3
    ready_only_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !$past(mem_ack && mem_wr));
endmodule

// File: tb/sim_dcache2_top.sv
module sim_dcache2_top;
    localparam int CLK_NS = 10;
    localparam int SETS   = 4;
    localparam int TAG_W  = 29;
    localparam int IDX_W  = 2;
    localparam int AW     = IDX_W + 6;
    localparam int LINE_W = 512;
    localparam int MA_W   = TAG_W + IDX_W;
    localparam int NRAND  = 400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic [AW-1:0]     cpu_addr = '0;
    logic [TAG_W-1:0]  cpu_tag = '0;
    logic              cpu_we = 1'b0;
    logic [31:0]       cpu_wdata = '0;
    logic [3:0]        cpu_be = '0;
    logic              cpu_ready;
    logic [31:0]       cpu_rdata;
    logic              mem_rd, mem_wr;
    logic [MA_W-1:0]   mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic [LINE_W-1:0] mem_rdata = '0;
    logic              mem_ack = 1'b0;

    dcache2_top #(.SETS(SETS), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_tag(cpu_tag), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_NS/2) clk = ~clk;

    // next-level memory, indexed by {tag[1:0], index}
    logic [LINE_W-1:0] bmem [16];
    logic [31:0]       shadow [16][16];

    // bench model of cache state
    bit m_v [SETS][2];
    bit m_d [SETS][2];
    int m_t [SETS][2];
    bit m_old [SETS];

    int n_chk = 0, n_bad = 0;
    int n_rd, n_wr;
    bit wr_after_rd;
    logic [MA_W-1:0]   last_wr_addr, last_rd_addr;
    logic [LINE_W-1:0] last_wr_line;
    int wait_cnt = 0;
    bit done = 0;

    function automatic logic [31:0] init_word(int la, int w);
        return 32'h5A00_0000 ^ (la << 12) ^ (w * 32'h0001_0101);
    endfunction

    function automatic logic [LINE_W-1:0] shadow_line(int la);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = shadow[la][w];
        return l;
    endfunction

    task automatic chk(bit ok, string msg, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (rst_n && (mem_rd || mem_wr)) begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                end else begin
                    chk(!(mem_rd && mem_wr), "R10 single strobe per transaction",
                        {mem_rd, mem_wr}, 2'b01);
                    if (mem_wr) begin
                        bmem[mem_addr[3:0]] = mem_wdata;
                        n_wr++;
                        if (n_rd > 0) wr_after_rd = 1;
                        last_wr_addr = mem_addr;
                        last_wr_line = mem_wdata;
                    end else begin
                        mem_rdata = bmem[mem_addr[3:0]];
                        n_rd++;
                        last_rd_addr = mem_addr;
                    end
                    mem_ack  = 1'b1;
                    wait_cnt = $urandom % 3;
                end
            end
        end
    end

    task automatic access(int idx, int tg, int wsel, bit we, logic [31:0] wd,
                          logic [3:0] be, string lbl);
        bit hit = 0;
        int hw = 0, vic = 0, lat = 0, la, vla;
        bit exp_wr;
        logic [31:0] got, exp;
        for (int w = 0; w < 2; w++) if (m_v[idx][w] && m_t[idx][w] == tg) begin hit = 1; hw = w; end
        if (!m_v[idx][0]) vic = 0;
        else if (!m_v[idx][1]) vic = 1;
        else vic = m_old[idx];
        exp_wr = !hit && m_v[idx][vic] && m_d[idx][vic];
        vla = (m_t[idx][vic] << 2) | idx;
        la  = (tg << 2) | idx;
        n_rd = 0; n_wr = 0; wr_after_rd = 0;
        cpu_req   = 1'b1;
        cpu_addr  = {idx[IDX_W-1:0], wsel[3:0], 2'b00};
        cpu_tag   = TAG_W'(tg);
        cpu_we    = we;
        cpu_wdata = wd;
        cpu_be    = be;
        forever begin
            @(negedge clk);
            lat++;
            if (cpu_ready) break;
        end
        got = cpu_rdata;
        cpu_req = 1'b0;
        if (hit) begin
            chk(lat == 1, {lbl, " R3 hit answered one cycle after take"}, lat, 1);
            chk(n_rd == 0 && n_wr == 0,
                {lbl, we ? " R4 store hit stays local" : " R2/R6 hit without memory traffic"},
                n_rd + n_wr, 0);
        end else begin
            chk(n_rd == 1, {lbl, " R5/R6/R7 one refill on miss"}, n_rd, 1);
            chk(last_rd_addr == MA_W'(la), {lbl, " R5 refill line address"}, last_rd_addr, la);
            chk(n_wr == (exp_wr ? 1 : 0),
                {lbl, exp_wr ? " R8 dirty victim written once" : " R9 clean victim not written"},
                n_wr, exp_wr);
            if (exp_wr) begin
                chk(last_wr_addr == MA_W'(vla), {lbl, " R8 write-back address"}, last_wr_addr, vla);
                chk(last_wr_line == shadow_line(vla), {lbl, " R8 write-back data"},
                    last_wr_line, shadow_line(vla));
                chk(!wr_after_rd, {lbl, " R8 write-back precedes refill"}, wr_after_rd, 0);
            end
        end
        if (!we) begin
            exp = shadow[la][wsel];
            chk(got == exp, {lbl, " R3 load data"}, got, exp);
        end else begin
            for (int b = 0; b < 4; b++)
                if (be[b]) shadow[la][wsel][b*8 +: 8] = wd[b*8 +: 8];
        end
        if (!hit) begin
            m_v[idx][vic] = 1; m_t[idx][vic] = tg; m_d[idx][vic] = 0; hw = vic;
        end
        m_old[idx] = ~hw[0];
        if (we) m_d[idx][hw] = 1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int la = 0; la < 16; la++)
            for (int w = 0; w < 16; w++) begin
                shadow[la][w] = init_word(la, w);
                bmem[la][w*32 +: 32] = init_word(la, w);
            end
        repeat (3) @(negedge clk);
        chk(!cpu_ready && !mem_rd && !mem_wr, "R1 outputs idle in reset",
            {cpu_ready, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !mem_rd && !mem_wr, "R1 outputs idle after reset",
            {cpu_ready, mem_rd, mem_wr}, 0);
        access(0, 1, 3, 0, 0, 0, "R1 first access misses");
        access(0, 2, 5, 0, 0, 0, "R7 empty way filled");
        access(0, 1, 3, 0, 0, 0, "R2 both lines resident");
        access(0, 2, 5, 1, 32'hDEAD_BEEF, 4'b0101, "R4 partial store hit");
        access(0, 2, 5, 0, 0, 0, "R4 merged bytes");
        access(0, 1, 0, 0, 0, 0, "R6 touch older line");
        access(0, 3, 7, 0, 0, 0, "R6/R8 dirty victim by recency");
        access(0, 2, 5, 0, 0, 0, "R8/R9 reload after write-back");
        access(1, 0, 0, 1, 32'h1234_5678, 4'b1111, "R5 store miss allocates");
        access(1, 0, 0, 0, 0, 0, "R5 allocated data");
        for (int i = 0; i < NRAND; i++) begin
            access($urandom % 4, $urandom % 4, $urandom % 16, 1'($urandom % 2),
                   $urandom, 4'($urandom % 15 + 1), "random");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule